// File: doc/BRIEF.md
# Accumulator-Side Register File

This block holds the eight general-purpose registers of a small accumulator CPU. A single write operation can load any subset of the registers from one of four sources: a constant zero, the operand field of the current instruction, the ALU result, or a word read from data memory. A 2-bit source code picks the source. An 8-bit one-hot mask, normally the low byte of the operand, picks the destination registers. A global write enable gates the whole operation.

One combinational read port returns the register named by a 3-bit binary index, normally the low three bits of the operand. Each register is built as a flop behind a hold/load multiplexer. A register changes only when the write enable is high and its own mask bit is set. The datapath width is a parameter. Instruction decoding is left to the surrounding control unit.

Top module: `acc_regfile`

## Requirements
- R1: An active-low reset (`rst_n` = 0) clears all eight registers to zero asynchronously, so every read index returns 0 afterwards.
- R2: Source code `src_sel` = 2'b00 writes an all-zero word into the selected registers at the next rising clock edge.
- R3: Source code `src_sel` = 2'b01 writes `opnd_data` into the selected registers at the next rising clock edge.
- R4: Source code `src_sel` = 2'b10 writes `alu_data` into the selected registers at the next rising clock edge.
- R5: Source code `src_sel` = 2'b11 writes `mem_data` into the selected registers at the next rising clock edge.
- R6: Bit k of `wr_onehot` (bit 0 = R0, bit 7 = R7) selects register Rk. A write changes only the registers whose mask bit is 1, and every other register keeps its old value.
- R7: While `wr_en` is 0, no register changes, whatever values the mask, source code and data buses carry.
- R8: When `wr_onehot` has several bits set, every selected register loads the same source word in the same cycle. An all-zero mask loads nothing.
- R9: The read port is combinational. `rd_data` shows register R[`rd_idx`] in the same cycle that `rd_idx` changes, with `rd_idx` a binary index (3'd0 = R0 … 3'd7 = R7).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Global write enable; gates all register loads |
| src_sel | input | 2 | Write source: 00 zero, 01 operand, 10 ALU, 11 memory |
| opnd_data | input | DATA_W | Operand data from the instruction |
| alu_data | input | DATA_W | ALU result |
| mem_data | input | DATA_W | Data memory read word |
| wr_onehot | input | NREG | Destination mask; bit k selects Rk |
| rd_idx | input | IDX_W | Binary read index |
| rd_data | output | DATA_W | Contents of the indexed register |

## Verification
A wrong internal state appears at the ports only when the affected register is read. A missed load, a load into an unselected register, or a load from the wrong source shows on `rd_data` the first time that register is indexed, in the cycle after the write edge. The bench therefore reads back every register after each write, so a fault in one register cell or in the source multiplexer shows within a few cycles. A fault in the read multiplexer shows at once, because the read path has no register in it.

// File: rtl/acc_rf_pkg.sv
package acc_rf_pkg;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'b00,
    SRC_OPND = 2'b01,
    SRC_ALU  = 2'b10,
    SRC_MEM  = 2'b11
  } rf_src_e;

  // Load strobe for one register: global enable AND its mask bit.
  function automatic logic cell_load(input logic en, input logic mask_bit);
    return en & mask_bit;
  endfunction

endpackage

// File: rtl/acc_rf_src_mux.sv
module acc_rf_src_mux
  import acc_rf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  rf_src_e           sel,
  input  logic [DATA_W-1:0] opnd,
  input  logic [DATA_W-1:0] alu,
  input  logic [DATA_W-1:0] mem,
  output logic [DATA_W-1:0] wdata
);

  always_comb begin
    unique case (sel)
      SRC_ZERO: wdata = '0;
      SRC_OPND: wdata = opnd;
      SRC_ALU:  wdata = alu;
      SRC_MEM:  wdata = mem;
      default:  wdata = '0;
    endcase
  end

endmodule

// File: rtl/acc_rf_cell.sv
module acc_rf_cell #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] nxt;

  // 2:1 hold/load selector
  assign nxt = ld ? d : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  a_r6_cell_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> q == $past(d));

  a_r7_cell_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> q == $past(q));

endmodule

// File: rtl/acc_rf_rd_mux.sv
module acc_rf_rd_mux #(
  parameter int DATA_W = 8,
  parameter int NREG   = 8,
  parameter int IDX_W  = 3
) (
  input  logic [NREG-1:0][DATA_W-1:0] regs,
  input  logic [IDX_W-1:0]            idx,
  output logic [DATA_W-1:0]           rd
);

  always_comb begin
    rd = '0;
    for (int k = 0; k < NREG; k++) begin
      if (idx == IDX_W'(k)) rd = regs[k];
    end
  end

endmodule

// File: rtl/acc_regfile.sv
module acc_regfile
  import acc_rf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NREG   = 8,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        src_sel,
  input  logic [DATA_W-1:0] opnd_data,
  input  logic [DATA_W-1:0] alu_data,
  input  logic [DATA_W-1:0] mem_data,
  input  logic [NREG-1:0]   wr_onehot,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  rf_src_e                     src_e;
  logic [DATA_W-1:0]           wdata;
  logic [NREG-1:0]             load_vec;
  logic [NREG-1:0][DATA_W-1:0] regs_q;

  assign src_e = rf_src_e'(src_sel);

  acc_rf_src_mux #(.DATA_W(DATA_W)) i_src_mux (
    .sel   (src_e),
    .opnd  (opnd_data),
    .alu   (alu_data),
    .mem   (mem_data),
    .wdata (wdata)
  );

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    assign load_vec[k] = cell_load(wr_en, wr_onehot[k]);

    acc_rf_cell #(.DATA_W(DATA_W)) i_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (load_vec[k]),
      .d     (wdata),
      .q     (regs_q[k])
    );

    a_r2_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_onehot[k] && src_sel == 2'b00) |=> regs_q[k] == '0);

    a_r3_opnd_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_onehot[k] && src_sel == 2'b01) |=> regs_q[k] == $past(opnd_data));

    a_r4_alu_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_onehot[k] && src_sel == 2'b10) |=> regs_q[k] == $past(alu_data));

    a_r5_mem_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_onehot[k] && src_sel == 2'b11) |=> regs_q[k] == $past(mem_data));

    a_r6_unselected_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_onehot[k] |=> regs_q[k] == $past(regs_q[k]));
  end

  a_r7_no_write_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> regs_q == $past(regs_q));

  a_r8_multi_same: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_onehot[0] && wr_onehot[NREG-1]) |=> regs_q[0] == regs_q[NREG-1]);

  acc_rf_rd_mux #(.DATA_W(DATA_W), .NREG(NREG), .IDX_W(IDX_W)) i_rd_mux (
    .regs (regs_q),
    .idx  (rd_idx),
    .rd   (rd_data)
  );

endmodule

// File: tb/test_acc_regfile.sv
module test_acc_regfile;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] src_sel = 2'b00;
  logic [7:0] opnd_data = '0, alu_data = '0, mem_data = '0;
  logic [7:0] wr_onehot = '0;
  logic [2:0] rd_idx = '0;
  logic [7:0] rd_data;

  int checks = 0;
  int failures = 0;

  logic [7:0] mdl [8];
  int    q_idx [$];
  logic [7:0] q_exp [$];
  string q_tag [$];

  always #5 clk = ~clk;

  acc_regfile i_acc_regfile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .src_sel(src_sel),
    .opnd_data(opnd_data), .alu_data(alu_data), .mem_data(mem_data),
    .wr_onehot(wr_onehot), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  // Driver: one write cycle; model update follows the requirements.
  task automatic do_write(input logic en, input logic [1:0] src, input logic [7:0] mask,
                          input logic [7:0] op, input logic [7:0] al, input logic [7:0] me);
    logic [7:0] val;
    @(negedge clk);
    wr_en = en; src_sel = src; wr_onehot = mask;
    opnd_data = op; alu_data = al; mem_data = me;
    case (src)
      2'b00: val = 8'h00;
      2'b01: val = op;
      2'b10: val = al;
      default: val = me;
    endcase
    @(negedge clk);
    if (en) for (int k = 0; k < 8; k++) if (mask[k]) mdl[k] = val;
    wr_en = 1'b0;
    wr_onehot = 8'h00;
  endtask

  // Driver: set read index and push expected item.
  task automatic rd_expect(input int idx, input string tag);
    @(negedge clk);
    rd_idx = idx[2:0];
    q_idx.push_back(idx);
    q_exp.push_back(mdl[idx]);
    q_tag.push_back(tag);
  endtask

  task automatic read_all(input string tag);
    for (int k = 0; k < 8; k++) rd_expect(k, tag);
  endtask

  // Monitor: compares 1 ns after each push, well away from the clock edge.
  initial begin
    forever begin
      wait (q_idx.size() > 0);
      #1;
      begin
        int i; logic [7:0] e; string t;
        i = q_idx.pop_front(); e = q_exp.pop_front(); t = q_tag.pop_front();
        checks++;
        if (rd_data !== e) begin
          failures++;
          $display("FAIL %s: R%0d read %h expected %h", t, i, rd_data, e);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) mdl[k] = 8'h00;
    // Garbage on write inputs during reset must not matter.
    wr_en = 1'b1; wr_onehot = 8'hFF; src_sel = 2'b11; mem_data = 8'hA5;
    repeat (3) @(negedge clk);
    wr_en = 1'b0; wr_onehot = 8'h00;
    rst_n = 1'b1;
    read_all("R1 reset");

    // Single-register writes, each source
    do_write(1'b1, 2'b01, 8'b0000_0001, 8'h3C, 8'h11, 8'h22); read_all("R3 opnd write R0");
    do_write(1'b1, 2'b10, 8'b0000_0100, 8'h33, 8'hC7, 8'h44); read_all("R4 alu write R2");
    do_write(1'b1, 2'b11, 8'b1000_0000, 8'h55, 8'h66, 8'h9E); read_all("R5 mem write R7");
    do_write(1'b1, 2'b11, 8'b0001_0000, 8'h00, 8'h00, 8'hFF); read_all("R6 write R4 only");

    // Write-enable low: nothing changes
    do_write(1'b0, 2'b01, 8'hFF, 8'hEE, 8'hDD, 8'hCC); read_all("R7 wr_en low");

    // Multi-bit mask and empty mask
    do_write(1'b1, 2'b10, 8'b0110_1010, 8'h01, 8'h5A, 8'h02); read_all("R8 multi mask");
    do_write(1'b1, 2'b01, 8'h00, 8'h77, 8'h77, 8'h77); read_all("R8 empty mask");

    // Zero source clears selected registers only
    do_write(1'b1, 2'b00, 8'b1000_0011, 8'hFF, 8'hFF, 8'hFF); read_all("R2 zero write");

    // Fill all, then back-to-back reads in reverse order (combinational port)
    do_write(1'b1, 2'b01, 8'hFF, 8'hB4, 8'h00, 8'h00);
    do_write(1'b1, 2'b11, 8'b0000_0010, 8'h00, 8'h00, 8'h81);
    for (int k = 7; k >= 0; k--) rd_expect(k, "R9 combinational read");

    // Read index changed mid-cycle, away from any edge
    @(negedge clk); #2;
    rd_idx = 3'd1;
    #1;
    checks++;
    if (rd_data !== 8'h81) begin
      failures++;
      $display("FAIL R9 mid-cycle read: R1 read %h expected %h", rd_data, 8'h81);
    end

    // Reset again mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < 8; k++) mdl[k] = 8'h00;
    read_all("R1 second reset");

    wait (q_idx.size() == 0);
    #3;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule